// File: doc/BRIEF.md
# Software Write-Lock Key Sequence Guard

This block sits beside the page-write controller of one 32 KB EEPROM block and watches every qualified byte write (15-bit address, 8-bit data). It decides, in the same cycle as the write, whether that byte may be passed on to the array. A three-write key code turns write-locking on and, at the same time, opens one page window. A six-write key code turns locking off and also opens one page window. A lock flag is kept for the block. The flag survives ordinary reset and is cleared only by the first-power-up clear input. Each 32 KB block uses its own instance, so each block has its own flag.

The page controller reports the end of a page window with a one-cycle pulse. When that pulse ends a window opened by a key code, the flag takes its new value. A refused write still starts the page controller's own timers, because that controller sees the same write event. Only the array update is withheld. Key writes never reach the array.

Top module: `swp_guard`

## Requirements
- R1: After `fresh_n` has been low, `prot_on` reads 0. After any reset, the sequence matcher starts from idle.
- R2: `wr_permit` is 0 in every cycle in which `wr_vld` is 0.
- R3: The lock code is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. A write that advances a key code gets `wr_permit` = 0. After the third write, every write gets `wr_permit` = 1 until the next `win_end`.
- R4: After the lock code, `prot_on` becomes 1 in the cycle after the `win_end` pulse that closes the window, and not before. This holds even if no data write came in between.
- R5: The unlock code has six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. It opens a window like R3. `prot_on` becomes 0 in the cycle after the closing `win_end`.
- R6: While `prot_on` is 1, a write outside an opened window gets `wr_permit` = 0.
- R7: A write that does not advance the current partial code returns the matcher to idle. While `prot_on` is 0, that write gets `wr_permit` = 1.
- R8: Pulsing `rst_n` leaves `prot_on` unchanged.
- R9: A `win_end` pulse closes any open window and abandons any partial code. The next write is judged from idle.
- R10: `prot_on` changes only in the cycle right after a `win_end` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the matcher, released synchronously |
| fresh_n | input | 1 | Active-low first-power-up clear of the lock flag |
| wr_vld | input | 1 | One qualified byte write this cycle |
| wr_addr | input | 15 | Byte address within the block |
| wr_data | input | 8 | Byte data |
| win_end | input | 1 | One-cycle pulse: the page window has expired |
| wr_permit | output | 1 | This write may be programmed into the array |
| prot_on | output | 1 | Lock flag of this block |

## Verification
The assertions assume that `win_end` and `wr_vld` are never high in the same cycle. They also assume that `win_end` is a single-cycle pulse from the page controller. The assertions judge writes at the idle and open states and do not depend on the data written to non-key addresses. The stimulus therefore draws each cycle as exactly one of four choices: a write, a window-end pulse, an idle cycle, or a reset pulse. Writes are biased towards the key address/data pairs so that full codes, broken codes and restarts all occur often.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_OPEN = 3'd3,
    ST_D3   = 3'd4,
    ST_D4   = 3'd5,
    ST_D5   = 3'd6
  } seq_st_e;

  typedef struct packed {
    logic aa_hi;   // first key byte at the high key address
    logic x55_lo;  // second key byte at the low key address
    logic en_hi;   // lock command at the high key address
    logic ds1_hi;  // unlock prefix command at the high key address
    logic ds2_hi;  // unlock final command at the high key address
  } key_hit_t;
endpackage

// File: rtl/swp_rst_sync.sv
module swp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/swp_key_match.sv
module swp_key_match
  import swp_pkg::*;
#(
  parameter int                ADDR_W  = 15,
  parameter int                DATA_W  = 8,
  parameter logic [ADDR_W-1:0] ADR_HI  = 'h5555,
  parameter logic [ADDR_W-1:0] ADR_LO  = 'h2AAA,
  parameter logic [DATA_W-1:0] D_FIRST = 'hAA,
  parameter logic [DATA_W-1:0] D_SECND = 'h55,
  parameter logic [DATA_W-1:0] D_LOCK  = 'hA0,
  parameter logic [DATA_W-1:0] D_UNL1  = 'h80,
  parameter logic [DATA_W-1:0] D_UNL2  = 'h20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output key_hit_t          hit
);
  logic at_hi, at_lo;

  always_comb begin
    at_hi      = (addr == ADR_HI);
    at_lo      = (addr == ADR_LO);
    hit.aa_hi  = at_hi && (data == D_FIRST);
    hit.x55_lo = at_lo && (data == D_SECND);
    hit.en_hi  = at_hi && (data == D_LOCK);
    hit.ds1_hi = at_hi && (data == D_UNL1);
    hit.ds2_hi = at_hi && (data == D_UNL2);
  end
endmodule

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm
  import swp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_vld,
  input  key_hit_t hit,
  input  logic     win_end,
  input  logic     prot_on,
  output logic     wr_permit,
  output logic     upd_en,
  output logic     upd_val,
  output seq_st_e  state_q
);
  seq_st_e state_n;
  logic    pend_q, pend_n;
  logic    adv, st_en;

  // next-state process
  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    adv     = 1'b0;
    if (wr_vld) begin
      unique case (state_q)
        ST_IDLE: if (hit.aa_hi)  begin state_n = ST_K1; adv = 1'b1; end
        ST_K1:   if (hit.x55_lo) begin state_n = ST_K2; adv = 1'b1; end
        ST_K2: begin
          if (hit.en_hi) begin
            state_n = ST_OPEN; pend_n = 1'b1; adv = 1'b1;
          end else if (hit.ds1_hi) begin
            state_n = ST_D3; adv = 1'b1;
          end
        end
        ST_D3:   if (hit.aa_hi)  begin state_n = ST_D4; adv = 1'b1; end
        ST_D4:   if (hit.x55_lo) begin state_n = ST_D5; adv = 1'b1; end
        ST_D5: begin
          if (hit.ds2_hi) begin
            state_n = ST_OPEN; pend_n = 1'b0; adv = 1'b1;
          end
        end
        ST_OPEN: ;
        default: state_n = ST_IDLE;
      endcase
      if (!adv && state_q != ST_OPEN) state_n = ST_IDLE;
    end
    if (win_end) state_n = ST_IDLE;
  end

  assign st_en     = wr_vld | win_end;
  assign wr_permit = wr_vld && ((state_q == ST_OPEN) || (!adv && !prot_on));
  assign upd_en    = win_end && (state_q == ST_OPEN);
  assign upd_val   = pend_q;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else if (st_en) begin
      state_q <= state_n;
      pend_q  <= pend_n;
    end
  end
endmodule

// File: rtl/swp_prot_flag.sv
module swp_prot_flag (
  input  logic clk,
  input  logic clr_n,
  input  logic upd_en,
  input  logic upd_val,
  output logic prot_q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      prot_q <= 1'b0;
    else if (upd_en) prot_q <= upd_val;
  end
endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fresh_n,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_end,
  output logic              wr_permit,
  output logic              prot_on
);
  logic     rst_sn, fresh_sn;
  key_hit_t hit;
  logic     upd_en, upd_val;
  seq_st_e  state_q;

  swp_rst_sync #(.STAGES(SYNC_N)) u_rs_seq (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sn));

  swp_rst_sync #(.STAGES(SYNC_N)) u_rs_flag (
    .clk(clk), .arst_n(fresh_n), .srst_n(fresh_sn));

  swp_key_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_key (
    .addr(wr_addr), .data(wr_data), .hit(hit));

  swp_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sn), .wr_vld(wr_vld), .hit(hit),
    .win_end(win_end), .prot_on(prot_on), .wr_permit(wr_permit),
    .upd_en(upd_en), .upd_val(upd_val), .state_q(state_q));

  swp_prot_flag u_flag (
    .clk(clk), .clr_n(fresh_sn), .upd_en(upd_en), .upd_val(upd_val),
    .prot_q(prot_on));
endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              wr_vld,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              win_end,
  input logic              wr_permit,
  input logic              prot_on,
  input logic [2:0]        st
);
  logic first_key;
  assign first_key = (wr_addr == ADDR_W'('h5555)) && (wr_data == DATA_W'('hAA));

  p_no_permit_idle_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_vld |-> !wr_permit);

  p_key_held_back_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (st == 3'd0 && wr_vld && first_key) |-> !wr_permit);

  p_window_admits_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (st == 3'd3 && wr_vld) |-> wr_permit);

  p_locked_refuses_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (st == 3'd0 && wr_vld && prot_on) |-> !wr_permit);

  p_plain_write_passes_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (st == 3'd0 && wr_vld && !prot_on && !first_key) |-> wr_permit);

  p_window_closes_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    win_end |=> (st == 3'd0));

  p_flag_moves_on_end_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    !win_end |=> $stable(prot_on));
endmodule

bind swp_guard swp_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_ok(rst_sn & fresh_sn), .wr_vld(wr_vld), .wr_addr(wr_addr),
  .wr_data(wr_data), .win_end(win_end), .wr_permit(wr_permit),
  .prot_on(prot_on), .st(state_q));

// File: tb/swp_guard_bench.sv
`timescale 1ns/1ps
module swp_guard_bench;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n, fresh_n, wr_vld, win_end;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_permit, prot_on;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model: 0 idle,1 k1,2 k2,3 open,4 d3,5 d4,6 d5
  int m_st   = 0;
  bit m_pend = 1'b0;
  bit m_prot = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  swp_guard u_swp_guard (
    .clk(clk), .rst_n(rst_n), .fresh_n(fresh_n), .wr_vld(wr_vld),
    .wr_addr(wr_addr), .wr_data(wr_data), .win_end(win_end),
    .wr_permit(wr_permit), .prot_on(prot_on));

  function automatic bit is_k(logic [14:0] a, logic [7:0] d, logic [14:0] ka, logic [7:0] kd);
    return (a == ka) && (d == kd);
  endfunction

  // returns next model state, -1 if the write does not advance the code
  function automatic int adv_to(int st, logic [14:0] a, logic [7:0] d);
    case (st)
      0: return is_k(a, d, 15'h5555, 8'hAA) ? 1 : -1;
      1: return is_k(a, d, 15'h2AAA, 8'h55) ? 2 : -1;
      2: if (is_k(a, d, 15'h5555, 8'hA0)) return 3;
         else return is_k(a, d, 15'h5555, 8'h80) ? 4 : -1;
      4: return is_k(a, d, 15'h5555, 8'hAA) ? 5 : -1;
      5: return is_k(a, d, 15'h2AAA, 8'h55) ? 6 : -1;
      6: return is_k(a, d, 15'h5555, 8'h20) ? 3 : -1;
      default: return -1;
    endcase
  endfunction

  function automatic bit exp_permit(logic [14:0] a, logic [7:0] d);
    if (m_st == 3) return 1'b1;
    if (adv_to(m_st, a, d) >= 0) return 1'b0;
    return !m_prot;
  endfunction

  task automatic check(bit got, bit exp, string req, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  // one cycle: checks flag, drives, checks permit, updates model
  task automatic cyc(bit v, logic [14:0] a, logic [7:0] d, bit we, string req);
    int nx;
    @(negedge clk);
    check(prot_on, m_prot, "R10", "prot_on");
    wr_vld = v; wr_addr = a; wr_data = d; win_end = we;
    #2;
    if (v) check(wr_permit, exp_permit(a, d), req, "wr_permit");
    else   check(wr_permit, 1'b0, "R2", "wr_permit idle");
    if (v) begin
      if (m_st != 3) begin
        nx = adv_to(m_st, a, d);
        if (nx == 3) m_pend = (m_st == 2);
        m_st = (nx < 0) ? 0 : nx;
      end
    end
    if (we) begin
      if (m_st == 3) m_prot = m_pend;
      m_st = 0;
    end
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d, string req);
    cyc(1'b1, a, d, 1'b0, req);
  endtask

  task automatic wend();
    cyc(1'b0, 15'h0, 8'h0, 1'b1, "R9");
  endtask

  task automatic lock_code(string req);
    wr(15'h5555, 8'hAA, req); wr(15'h2AAA, 8'h55, req); wr(15'h5555, 8'hA0, req);
  endtask

  task automatic unlock_code();
    wr(15'h5555, 8'hAA, "R5"); wr(15'h2AAA, 8'h55, "R5"); wr(15'h5555, 8'h80, "R5");
    wr(15'h5555, 8'hAA, "R5"); wr(15'h2AAA, 8'h55, "R5"); wr(15'h5555, 8'h20, "R5");
  endtask

  task automatic pulse_rst();
    @(negedge clk);
    wr_vld = 1'b0; win_end = 1'b0; rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_st = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [14:0] ka [5];
    logic [7:0]  kd [5];
    ka = '{15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h5555};
    kd = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h20};
    void'($urandom(32'd20240607));
    rst_n = 1'b0; fresh_n = 1'b0; wr_vld = 1'b0; win_end = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; fresh_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(prot_on, 1'b0, "R1", "prot_on after fresh clear");
    cyc(1'b0, 15'h0, 8'h0, 1'b0, "R2");

    // R7 plain writes while unlocked, and a broken code
    wr(15'h0100, 8'h12, "R7");
    wr(15'h5555, 8'hAA, "R3");
    wr(15'h0101, 8'h34, "R7");   // breaks the code: permitted
    wr(15'h2AAA, 8'h55, "R7");   // judged from idle: plain write

    // R3/R4 lock code with data, flag only after window end
    lock_code("R3");
    wr(15'h1234, 8'h9C, "R3");
    wr(15'h5555, 8'hAA, "R3");   // inside window: data
    check(prot_on, 1'b0, "R4", "prot_on before window end");
    wend();
    @(negedge clk);
    check(prot_on, 1'b1, "R4", "prot_on after window end");

    // R6 locked writes refused
    wr(15'h0200, 8'h01, "R6");
    wr(15'h7FFF, 8'hFF, "R6");

    // R8 reset keeps the flag
    pulse_rst();
    check(prot_on, 1'b1, "R8", "prot_on after rst_n pulse");

    // R3 prefix admits write while locked
    lock_code("R3");
    wr(15'h0300, 8'h55, "R3");
    wend();
    wr(15'h0301, 8'h66, "R9");   // window closed: refused

    // R9 partial code abandoned by window end
    wr(15'h5555, 8'hAA, "R9"); wr(15'h2AAA, 8'h55, "R9");
    wend();
    wr(15'h5555, 8'hA0, "R9");

    // R5 unlock, lock code with no data
    unlock_code();
    wr(15'h0400, 8'h77, "R5");
    check(prot_on, 1'b1, "R5", "prot_on before window end");
    wend();
    @(negedge clk);
    check(prot_on, 1'b0, "R5", "prot_on after unlock");
    lock_code("R4");
    wend();
    @(negedge clk);
    check(prot_on, 1'b1, "R4", "prot_on after empty lock window");
    unlock_code();
    wend();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(99);
      if (r < 45) begin
        int k;
        k = $urandom_range(4);
        wr(ka[k], kd[k], "R7");
      end else if (r < 75) begin
        wr(15'($urandom), 8'($urandom), "R6");
      end else if (r < 88) begin
        wend();
      end else if (r < 99) begin
        cyc(1'b0, 15'h0, 8'h0, 1'b0, "R2");
      end else begin
        pulse_rst();
        check(prot_on, m_prot, "R8", "prot_on after random reset");
      end
    end

    // R1 fresh clear
    @(negedge clk);
    fresh_n = 1'b0;
    @(negedge clk);
    fresh_n = 1'b1;
    m_prot = 1'b0;
    repeat (3) @(negedge clk);
    check(prot_on, 1'b0, "R1", "prot_on after second fresh clear");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule